// File: doc/BRIEF.md
# Branch and Call Sequencer

This block works out the program counter for the next instruction of a small 8-bit core with a 16-bit code space. The decoder hands it one instruction per one-cycle `instValid` strobe. Each instruction carries a kind code, two operand bytes, the current PC, the accumulator, the carry flag, a loop-counter value and, for ordinary instructions, their length in bytes. The sequencer returns a registered next PC and a taken flag one cycle later. It also returns the decremented loop count for the loop-branch kind.

Calls and returns use a byte-wide return-address stack held inside the block. A call stores the address of the instruction after it, one byte per cycle. A return reads that address back in the reverse order. During these two stack cycles `busy` is high and new strobes are not accepted. Three kinds of target can be formed: an 8-bit signed displacement from the following instruction, a full 16-bit address, and an 11-bit field placed inside the 2K-byte page of the following instruction.

Top module: `branch_call_seq`

## Requirements
- R1: While reset is held, and after it until the first instruction: pcValid=0, taken=0, busy=0, nextPc=0000h, loopCountOut=00h and stackPtr=07h.
- R2: Kind codes: 0 plain, 1 short jump, 2 jump-if-acc-zero, 3 jump-if-acc-nonzero, 4 jump-if-carry-clear, 5 decrement-and-branch, 6 long jump, 7 page call, 8 long call, 9 return. Codes 10 to 15 act as plain. A plain kind gives nextPc = curPc + instLen (1 to 3) with taken=0. All PC sums wrap modulo 65536.
- R3: Kinds 1 to 5 are 2 bytes long. When they branch, the target is curPc + 2 + opByte1 read as signed (-128..+127). When they do not, nextPc = curPc + 2 and taken=0. The short jump always branches.
- R4: Kind 2 branches only when accVal is 00h. Kind 3 branches only when accVal is not 00h.
- R5: Kind 4 branches when carryFlag=0 and falls through when carryFlag=1.
- R6: Kind 5 gives loopCountOut = loopCount - 1 (mod 256) and branches only if that result is not zero. A count of 00h therefore yields FFh and branches. Every other kind passes loopCount through unchanged.
- R7: Kind 6 is 3 bytes long and jumps to {opByte1, opByte2}, with opByte1 as the high byte.
- R8: Kind 7 is 2 bytes long. Its target is {(curPc+2)[15:11], opByte1[2:0], opByte2}, and it saves curPc + 2.
- R9: Kind 8 is 3 bytes long, jumps to {opByte1, opByte2} and saves curPc + 3. A call or return holds busy high for exactly two cycles after its strobe. nextPc, with taken=1, appears on the cycle after that.
- R10: A call pre-increments stackPtr before each write, storing the low byte of the saved address first and then the high byte, so stackPtr rises by 2.
- R11: Kind 9 reads the high byte and then the low byte, post-decrementing stackPtr each time. It sets nextPc to the restored address with taken=1, so nested calls return in last-in first-out order.
- R12: An instValid strobe that arrives while busy is high is ignored. It produces no pcValid pulse, no stack change and no change to the pending result.
- R13: pcValid is a one-cycle pulse per accepted instruction. It stays low throughout the stack cycles of a call or return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | One-cycle strobe presenting a decoded instruction |
| instKind | input | 4 | Instruction kind code (see R2) |
| instLen | input | 2 | Length in bytes of a plain instruction |
| opByte1 | input | 8 | First operand byte |
| opByte2 | input | 8 | Second operand byte |
| curPc | input | 16 | Address of the presented instruction |
| accVal | input | 8 | Accumulator value |
| carryFlag | input | 1 | Carry flag |
| loopCount | input | 8 | Loop counter before decrement |
| nextPc | output | 16 | Registered next program counter |
| taken | output | 1 | A control transfer was taken |
| pcValid | output | 1 | nextPc and taken are valid this cycle |
| busy | output | 1 | Stack transfer in progress |
| loopCountOut | output | 8 | Registered loop counter result |
| stackPtr | output | 8 | Current stack pointer |

## Verification
Two functions can meet in one cycle: accepting a new strobe, and running a call's byte pushes. The bench provokes this by raising `instValid` with a long jump during the first push cycle of a long call. It then checks that the call's own target still arrives on time. It also checks that no extra valid pulse follows and that the stack pointer moved by exactly two. Nested calls followed by two returns then show that the stored bytes were not disturbed.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [3:0] {
    K_SEQ   = 4'd0,
    K_SJMP  = 4'd1,
    K_JZ    = 4'd2,
    K_JNZ   = 4'd3,
    K_JNC   = 4'd4,
    K_DJNZ  = 4'd5,
    K_LJMP  = 4'd6,
    K_ACALL = 4'd7,
    K_LCALL = 4'd8,
    K_RET   = 4'd9
  } kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // instruction accepted this cycle
    logic pushLo;
    logic pushHi;
    logic popHi;
    logic popLo;
  } strobe_t;

  function automatic logic isCall(input logic [3:0] k);
    return (k == K_ACALL) || (k == K_LCALL);
  endfunction

  function automatic logic isStackKind(input logic [3:0] k);
    return isCall(k) || (k == K_RET);
  endfunction

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [3:0] instKind,
  output strobe_t    strb,
  output logic       busy
);

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_LO, S_PUSH_HI, S_POP_HI, S_POP_LO
  } state_e;

  state_e state, stateNext;
  logic   accept;

  assign accept = instValid && (state == S_IDLE);
  assign busy   = (state != S_IDLE);

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (accept && isCall(instKind))      stateNext = S_PUSH_LO;
        else if (accept && instKind == K_RET) stateNext = S_POP_HI;
      end
      S_PUSH_LO: stateNext = S_PUSH_HI;
      S_PUSH_HI: stateNext = S_IDLE;
      S_POP_HI:  stateNext = S_POP_LO;
      S_POP_LO:  stateNext = S_IDLE;
      default:   stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.capture = accept;
    strb.pushLo  = (state == S_PUSH_LO);
    strb.pushHi  = (state == S_PUSH_HI);
    strb.popHi   = (state == S_POP_HI);
    strb.popLo   = (state == S_POP_LO);
  end

endmodule

// File: rtl/bcs_dpath.sv
module bcs_dpath
  import bcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SP_W = 8,
  parameter int PAGE_W = 11,
  parameter logic [SP_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [3:0]        instKind,
  input  logic [1:0]        instLen,
  input  logic [DATA_W-1:0] opByte1,
  input  logic [DATA_W-1:0] opByte2,
  input  logic [2*DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] accVal,
  input  logic              carryFlag,
  input  logic [DATA_W-1:0] loopCount,
  output logic [2*DATA_W-1:0] nextPc,
  output logic              taken,
  output logic              pcValid,
  output logic [DATA_W-1:0] loopCountOut,
  output logic [SP_W-1:0]   stackPtr
);

  localparam int ADDR_W      = 2 * DATA_W;
  localparam int STACK_DEPTH = 1 << SP_W;

  logic [DATA_W-1:0] stackMem [STACK_DEPTH];
  logic [ADDR_W-1:0] pendTarget, retAddr;
  logic [DATA_W-1:0] hiByte;

  logic [ADDR_W-1:0] lenEff, seqPc, relTarget, longTarget, pageTarget;
  logic [ADDR_W-1:0] resolvedPc;
  logic [DATA_W-1:0] decCount;
  logic              branchTaken, isRelKind;
  logic [SP_W-1:0]   spInc, spDec;

  assign spInc = stackPtr + 1'b1;
  assign spDec = stackPtr - 1'b1;

  // Instruction length per kind
  always_comb begin
    case (instKind)
      K_SJMP, K_JZ, K_JNZ, K_JNC, K_DJNZ, K_ACALL: lenEff = ADDR_W'(2);
      K_LJMP, K_LCALL:                             lenEff = ADDR_W'(3);
      K_RET:                                       lenEff = ADDR_W'(1);
      default:                                     lenEff = ADDR_W'(instLen);
    endcase
  end

  assign seqPc      = curPc + lenEff;
  assign relTarget  = seqPc + {{(ADDR_W-DATA_W){opByte1[DATA_W-1]}}, opByte1};
  assign longTarget = {opByte1, opByte2};
  assign pageTarget = {seqPc[ADDR_W-1:PAGE_W], longTarget[PAGE_W-1:0]};
  assign decCount   = loopCount - 1'b1;
  assign isRelKind  = (instKind == K_SJMP) || (instKind == K_JZ) ||
                      (instKind == K_JNZ) || (instKind == K_JNC) ||
                      (instKind == K_DJNZ);

  always_comb begin
    case (instKind)
      K_SJMP:  branchTaken = 1'b1;
      K_JZ:    branchTaken = (accVal == '0);
      K_JNZ:   branchTaken = (accVal != '0);
      K_JNC:   branchTaken = !carryFlag;
      K_DJNZ:  branchTaken = (decCount != '0);
      K_LJMP:  branchTaken = 1'b1;
      default: branchTaken = 1'b0;
    endcase
  end

  always_comb begin
    if (!branchTaken)   resolvedPc = seqPc;
    else if (isRelKind) resolvedPc = relTarget;
    else                resolvedPc = longTarget;
  end

  // Result, pending call data and stack pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc       <= '0;
      taken        <= 1'b0;
      pcValid      <= 1'b0;
      loopCountOut <= '0;
      stackPtr     <= SP_RESET;
      pendTarget   <= '0;
      retAddr      <= '0;
      hiByte       <= '0;
    end else begin
      pcValid <= 1'b0;
      if (strb.capture) begin
        loopCountOut <= (instKind == K_DJNZ) ? decCount : loopCount;
        if (!isStackKind(instKind)) begin
          nextPc  <= resolvedPc;
          taken   <= branchTaken;
          pcValid <= 1'b1;
        end else if (isCall(instKind)) begin
          pendTarget <= (instKind == K_ACALL) ? pageTarget : longTarget;
          retAddr    <= seqPc;
        end
      end
      if (strb.pushLo) stackPtr <= spInc;
      if (strb.pushHi) begin
        stackPtr <= spInc;
        nextPc   <= pendTarget;
        taken    <= 1'b1;
        pcValid  <= 1'b1;
      end
      if (strb.popHi) begin
        hiByte   <= stackMem[stackPtr];
        stackPtr <= spDec;
      end
      if (strb.popLo) begin
        nextPc   <= {hiByte, stackMem[stackPtr]};
        taken    <= 1'b1;
        pcValid  <= 1'b1;
        stackPtr <= spDec;
      end
    end
  end

  // Stack storage, written at the pre-incremented pointer
  always_ff @(posedge clk) begin
    if (strb.pushLo) stackMem[spInc] <= retAddr[DATA_W-1:0];
    if (strb.pushHi) stackMem[spInc] <= retAddr[ADDR_W-1:DATA_W];
  end

endmodule

// File: rtl/branch_call_seq.sv
module branch_call_seq
  import bcs_pkg::*;
#(
  parameter logic [7:0] SP_RESET = 8'h07
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [3:0]  instKind,
  input  logic [1:0]  instLen,
  input  logic [7:0]  opByte1,
  input  logic [7:0]  opByte2,
  input  logic [15:0] curPc,
  input  logic [7:0]  accVal,
  input  logic        carryFlag,
  input  logic [7:0]  loopCount,
  output logic [15:0] nextPc,
  output logic        taken,
  output logic        pcValid,
  output logic        busy,
  output logic [7:0]  loopCountOut,
  output logic [7:0]  stackPtr
);

  strobe_t strb;

  bcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instKind(instKind),
    .strb(strb), .busy(busy)
  );

  bcs_dpath #(.DATA_W(8), .SP_W(8), .PAGE_W(11), .SP_RESET(SP_RESET)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .instKind(instKind),
    .instLen(instLen), .opByte1(opByte1), .opByte2(opByte2), .curPc(curPc),
    .accVal(accVal), .carryFlag(carryFlag), .loopCount(loopCount),
    .nextPc(nextPc), .taken(taken), .pcValid(pcValid),
    .loopCountOut(loopCountOut), .stackPtr(stackPtr)
  );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        instValid,
  input logic [3:0]  instKind,
  input logic [1:0]  instLen,
  input logic [7:0]  opByte1,
  input logic [7:0]  opByte2,
  input logic [15:0] curPc,
  input logic [7:0]  loopCount,
  input logic [15:0] nextPc,
  input logic        taken,
  input logic        pcValid,
  input logic        busy,
  input logic [7:0]  loopCountOut,
  input logic [7:0]  stackPtr
);

  logic acc;
  assign acc = instValid && !busy;

  AST_SEQ_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (acc && instKind == K_SEQ) |=>
      (pcValid && !taken && nextPc == $past(curPc) + 16'($past(instLen)))) else $error("seq");  // R2

  AST_LONG_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    (acc && instKind == K_LJMP) |=>
      (pcValid && taken && nextPc == {$past(opByte1), $past(opByte2)})) else $error("ljmp");  // R7

  AST_LOOP_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (acc && instKind == K_DJNZ) |=> (loopCountOut == $past(loopCount) - 8'd1)) else $error("djnz");  // R6

  AST_CALL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (acc && isStackKind(instKind)) |=> (busy && !pcValid)) else $error("busy");  // R9

  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stackPtr) |-> (busy || $fell(busy))) else $error("sp");  // R10

  AST_BUSY_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !pcValid) else $error("valid");  // R13

endmodule

bind branch_call_seq bcs_checker u_chk (
  .clk(clk), .rstN(rstN), .instValid(instValid), .instKind(instKind),
  .instLen(instLen), .opByte1(opByte1), .opByte2(opByte2), .curPc(curPc),
  .loopCount(loopCount), .nextPc(nextPc), .taken(taken), .pcValid(pcValid),
  .busy(busy), .loopCountOut(loopCountOut), .stackPtr(stackPtr)
);

// File: tb/branch_call_seq_test.sv
module branch_call_seq_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [3:0]  instKind = '0;
  logic [1:0]  instLen = '0;
  logic [7:0]  opByte1 = '0, opByte2 = '0, accVal = '0, loopCount = '0;
  logic [15:0] curPc = '0;
  logic        carryFlag = 1'b0;
  logic [15:0] nextPc;
  logic        taken, pcValid, busy;
  logic [7:0]  loopCountOut, stackPtr;

  int checks = 0;
  int failures = 0;
  logic [7:0] expSp = 8'h07;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_call_seq uut (.*);

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one instruction for one cycle; returns at the negedge after acceptance
  task automatic issue(input logic [3:0] k, input logic [7:0] o1, input logic [7:0] o2,
                       input logic [15:0] pc, input logic [7:0] a, input logic cy,
                       input logic [7:0] lc, input logic [1:0] ln);
    @(negedge clk);
    instKind = k; opByte1 = o1; opByte2 = o2; curPc = pc;
    accVal = a; carryFlag = cy; loopCount = lc; instLen = ln; instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic expectBranch(input string req, input logic [15:0] pc, input logic tk);
    chk(pcValid === 1'b1, req, 16'(pcValid), 16'd1);
    chk(nextPc === pc, req, nextPc, pc);
    chk(taken === tk, req, 16'(taken), 16'(tk));
  endtask

  // Stack kind: check two busy cycles, then the result
  task automatic stackOp(input string req, input logic [3:0] k, input logic [7:0] o1,
                         input logic [7:0] o2, input logic [15:0] pc, input logic [15:0] exp,
                         input bit push);
    issue(k, o1, o2, pc, 8'h00, 1'b0, 8'h00, 2'd0);
    chk(busy === 1'b1 && pcValid === 1'b0, {req, " R9 R13 busy1"}, {14'd0, busy, pcValid}, 16'h2);
    @(negedge clk);
    chk(busy === 1'b1 && pcValid === 1'b0, {req, " R9 busy2"}, {14'd0, busy, pcValid}, 16'h2);
    @(negedge clk);
    chk(busy === 1'b0, {req, " R9 idle"}, 16'(busy), 16'd0);
    expectBranch(req, exp, 1'b1);
    expSp = push ? expSp + 8'd2 : expSp - 8'd2;
    chk(stackPtr === expSp, {req, " R10 R11 sp"}, 16'(stackPtr), 16'(expSp));
  endtask

  task automatic t_reset;
    chk(pcValid === 1'b0 && taken === 1'b0 && busy === 1'b0, "R1 flags",
        {13'd0, pcValid, taken, busy}, 16'd0);
    chk(nextPc === 16'h0000, "R1 nextPc", nextPc, 16'h0000);
    chk(stackPtr === 8'h07, "R1 sp", 16'(stackPtr), 16'h0007);
    chk(loopCountOut === 8'h00, "R1 loop", 16'(loopCountOut), 16'h0000);
  endtask

  task automatic t_seq;
    issue(4'd0, 8'h00, 8'h00, 16'h1234, 8'h00, 1'b0, 8'h00, 2'd3);
    expectBranch("R2 seq len3", 16'h1237, 1'b0);
    @(negedge clk);
    chk(pcValid === 1'b0, "R13 pulse", 16'(pcValid), 16'd0);
    issue(4'd0, 8'h00, 8'h00, 16'hFFFF, 8'h00, 1'b0, 8'h00, 2'd1);
    expectBranch("R2 seq wrap", 16'h0000, 1'b0);
    issue(4'd12, 8'h55, 8'h66, 16'h0100, 8'h00, 1'b0, 8'h00, 2'd2);
    expectBranch("R2 unused kind", 16'h0102, 1'b0);
  endtask

  task automatic t_rel;
    issue(4'd1, 8'h10, 8'h00, 16'h0200, 8'h00, 1'b0, 8'h00, 2'd0);
    expectBranch("R3 sjmp fwd", 16'h0212, 1'b1);
    issue(4'd1, 8'h80, 8'h00, 16'h0010, 8'h00, 1'b0, 8'h00, 2'd0);
    expectBranch("R3 sjmp back wrap", 16'hFF92, 1'b1);
    issue(4'd1, 8'h05, 8'h00, 16'hFFFE, 8'h00, 1'b0, 8'h00, 2'd0);
    expectBranch("R3 sjmp fwd wrap", 16'h0005, 1'b1);
  endtask

  task automatic t_acc;
    issue(4'd2, 8'hFE, 8'h00, 16'h0400, 8'h00, 1'b0, 8'h00, 2'd0);
    expectBranch("R4 jz taken", 16'h0400, 1'b1);
    issue(4'd2, 8'hFE, 8'h00, 16'h0400, 8'h01, 1'b0, 8'h00, 2'd0);
    expectBranch("R4 jz fall", 16'h0402, 1'b0);
    issue(4'd3, 8'h7F, 8'h00, 16'h0400, 8'h80, 1'b0, 8'h00, 2'd0);
    expectBranch("R4 jnz taken", 16'h0481, 1'b1);
    issue(4'd3, 8'h7F, 8'h00, 16'h0400, 8'h00, 1'b0, 8'h00, 2'd0);
    expectBranch("R4 jnz fall", 16'h0402, 1'b0);
  endtask

  task automatic t_jnc;
    issue(4'd4, 8'h20, 8'h00, 16'h0800, 8'h00, 1'b0, 8'h00, 2'd0);
    expectBranch("R5 jnc cy0", 16'h0822, 1'b1);
    issue(4'd4, 8'h20, 8'h00, 16'h0800, 8'h00, 1'b1, 8'h00, 2'd0);
    expectBranch("R5 jnc cy1", 16'h0802, 1'b0);
  endtask

  task automatic t_djnz;
    issue(4'd5, 8'hFC, 8'h00, 16'h0900, 8'h00, 1'b0, 8'h00, 2'd0);
    expectBranch("R6 djnz zero count", 16'h08FE, 1'b1);
    chk(loopCountOut === 8'hFF, "R6 count wrap", 16'(loopCountOut), 16'h00FF);
    issue(4'd5, 8'hFC, 8'h00, 16'h0900, 8'h00, 1'b0, 8'h01, 2'd0);
    expectBranch("R6 djnz exit", 16'h0902, 1'b0);
    chk(loopCountOut === 8'h00, "R6 count exit", 16'(loopCountOut), 16'h0000);
    issue(4'd1, 8'h00, 8'h00, 16'h0000, 8'h00, 1'b0, 8'h33, 2'd0);
    chk(loopCountOut === 8'h33, "R6 pass through", 16'(loopCountOut), 16'h0033);
  endtask

  task automatic t_ljmp;
    issue(4'd6, 8'hBE, 8'hEF, 16'h0100, 8'h00, 1'b0, 8'h00, 2'd0);
    expectBranch("R7 ljmp", 16'hBEEF, 1'b1);
  endtask

  task automatic t_calls;
    stackOp("R9 lcall", 4'd8, 8'h40, 8'h00, 16'h1000, 16'h4000, 1'b1);
    stackOp("R8 acall page", 4'd7, 8'hFF, 8'h34, 16'h27FE, 16'h2F34, 1'b1);
    stackOp("R11 ret inner", 4'd9, 8'h00, 8'h00, 16'h2F40, 16'h2800, 1'b0);
    stackOp("R11 ret outer", 4'd9, 8'h00, 8'h00, 16'h4010, 16'h1003, 1'b0);
  endtask

  task automatic t_ignore;
    issue(4'd8, 8'h12, 8'h34, 16'h5000, 8'h00, 1'b0, 8'h00, 2'd0);
    // strobe during first push cycle must be dropped
    instKind = 4'd6; opByte1 = 8'hAA; opByte2 = 8'hBB; instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
    chk(busy === 1'b1, "R12 still busy", 16'(busy), 16'd1);
    @(negedge clk);
    expectBranch("R12 call survives", 16'h1234, 1'b1);
    expSp = expSp + 8'd2;
    chk(stackPtr === expSp, "R12 sp", 16'(stackPtr), 16'(expSp));
    @(negedge clk);
    chk(pcValid === 1'b0 && nextPc === 16'h1234, "R12 no extra pulse",
        nextPc, 16'h1234);
    stackOp("R12 R10 ret after ignore", 4'd9, 8'h00, 8'h00, 16'h1240, 16'h5003, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_rel();
    t_acc();
    t_jnc();
    t_djnz();
    t_ljmp();
    t_calls();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule